// File: doc/BRIEF.md
# Address-Transition Access Pulse Controller

This block gives a memory array with no clock-driven control a clocked way to decide when to do work. It keeps a snapshot of the last request it serviced. That snapshot holds the address bits and the read/write direction bit. While the access enable is high, any difference between the live request and the snapshot starts a fixed-length operation pulse. The pulse is routed to either the read strobe or the write strobe. When the enable is low, no pulse is ever issued, so a disabled memory does no internal work.

Repeating a request with the same address and the same direction starts nothing. The data latched by the last read pulse stays on the output, so a repeated read reuses it instead of running the array again. The first enabled request after reset always starts a pulse. A change that arrives while a pulse is running restarts the pulse from its beginning. A running count of started pulses is brought out so that suppression can be observed.

Top module: `atd_access_ctrl`

## Requirements
- R1: During and directly after reset, both strobes and `dvalid_o` are low, and `rdata_o` and `pulse_cnt_o` are zero.
- R2: With `en_i` high, a change on any single bit of `{we_i, addr_i}` starts a pulse. The pulse begins at the next rising clock edge and stays high for exactly PULSE_LEN cycles.
- R3: While `en_i` is low, no pulse starts, whatever the address and direction inputs do.
- R4: An enabled request equal to the last serviced request (same address, same `we_i`) starts no pulse. `rdata_o`, `dvalid_o` and `pulse_cnt_o` keep their values, even if `mem_rdata_i` differs.
- R5: The first enabled request after reset starts a pulse even when it equals the reset snapshot (address 0, read).
- R6: A request change during an active pulse restarts it. The strobe then stays high for PULSE_LEN cycles counted from the edge of the restart.
- R7: `we_i` = 0 selects a read, driven on `rd_stb_o`. `we_i` = 1 selects a write, driven on `wr_stb_o`. The two strobes are never high together.
- R8: At the edge that ends a read pulse, `rdata_o` captures `mem_rdata_i` and `dvalid_o` goes high. `dvalid_o` is low whenever a pulse is active, and it stays low after a write pulse ends.
- R9: `pulse_cnt_o` increases by exactly one for every pulse started, restarts included, and never changes otherwise.
- R10: A request changed while `en_i` is low is serviced with a pulse as soon as `en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Request address |
| we_i | input | 1 | Direction: 1 write, 0 read |
| en_i | input | 1 | Access enable, gates pulse start |
| mem_rdata_i | input | DW | Array read data, captured at the end of a read pulse |
| rd_stb_o | output | 1 | Read operation strobe |
| wr_stb_o | output | 1 | Write operation strobe |
| dvalid_o | output | 1 | Held read data valid |
| rdata_o | output | DW | Held read data |
| pulse_cnt_o | output | CW | Number of pulses started, wraps |

## Verification
A snapshot that updates at the wrong time shows up in two ways: a pulse appears on a repeated request, or a pulse is missing after a change. Either error is visible on the strobes one cycle after the request is applied, and `pulse_cnt_o` makes it permanent. A pulse timer that is off by one changes the strobe width, and that shows within PULSE_LEN + 1 cycles. It also moves the capture edge, so `rdata_o` holds the wrong word. A direction bit latched incorrectly sends the pulse to the other strobe, and for a write it leaves `dvalid_o` set when it should be low.

// File: rtl/atd_pkg.sv
package atd_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } atd_op_e;
endpackage

// File: rtl/atd_change_det.sv
module atd_change_det #(
  parameter int MW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] mon_i,
  input  logic          en_i,
  output logic          fire_o,
  output logic [MW-1:0] snap_o
);
  logic [MW-1:0] snap_q;
  logic          armed_q;
  logic          diff;

  // OR-reduction of per-bit differences against last serviced request
  assign diff   = |(mon_i ^ snap_q);
  assign fire_o = en_i & (diff | ~armed_q);
  assign snap_o = snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
    end else if (fire_o) begin
      snap_q  <= mon_i;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/atd_pulse_timer.sv
module atd_pulse_timer #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic end_o
);
  localparam int TW = $clog2(PULSE_LEN + 1);
  localparam logic [TW-1:0] LEN = TW'(PULSE_LEN);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;

  assign active_o = cnt_q != '0;
  assign end_o    = (cnt_q == ONE) & ~fire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (fire_i)   cnt_q <= LEN;
    else if (active_o) cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/atd_out_latch.sv
module atd_out_latch
  import atd_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          end_i,
  input  atd_op_e       op_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          dvalid_o,
  output logic [CW-1:0] pulse_cnt_o
);
  logic [DW-1:0] rdata_q;
  logic          dvalid_q;
  logic [CW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      dvalid_q <= 1'b0;
      pcnt_q   <= '0;
    end else begin
      if (fire_i) begin
        dvalid_q <= 1'b0;
        pcnt_q   <= pcnt_q + CW'(1);
      end else if (end_i) begin
        dvalid_q <= (op_i == OP_READ);
        if (op_i == OP_READ) rdata_q <= mem_rdata_i;
      end
    end
  end

  assign rdata_o     = rdata_q;
  assign dvalid_o    = dvalid_q;
  assign pulse_cnt_o = pcnt_q;
endmodule

// File: rtl/atd_access_ctrl.sv
module atd_access_ctrl
  import atd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int PULSE_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          en_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic          dvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] pulse_cnt_o
);
  localparam int MW = AW + 1;

  logic [MW-1:0] mon, snap;
  logic          fire, active, pend;
  atd_op_e       op;

  assign mon = {we_i, addr_i};

  atd_change_det #(.MW(MW)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mon_i (mon),
    .en_i  (en_i),
    .fire_o(fire),
    .snap_o(snap)
  );

  atd_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .active_o(active),
    .end_o   (pend)
  );

  assign op = atd_op_e'(snap[MW-1]);

  atd_out_latch #(.DW(DW), .CW(CW)) u_lat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .end_i      (pend),
    .op_i       (op),
    .mem_rdata_i(mem_rdata_i),
    .rdata_o    (rdata_o),
    .dvalid_o   (dvalid_o),
    .pulse_cnt_o(pulse_cnt_o)
  );

  assign rd_stb_o = active & (op == OP_READ);
  assign wr_stb_o = active & (op == OP_WRITE);
endmodule

// File: rtl/atd_access_ctrl_chk.sv
module atd_access_ctrl_chk #(
  parameter int CW        = 16,
  parameter int PULSE_LEN = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          rd_stb_o,
  input logic          wr_stb_o,
  input logic          dvalid_o,
  input logic [CW-1:0] pulse_cnt_o
);
  logic          act;
  logic [CW-1:0] seen_q;
  int unsigned   run_q;

  assign act = rd_stb_o | wr_stb_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      run_q  <= 0;
    end else begin
      seen_q <= pulse_cnt_o;
      if (act && pulse_cnt_o != seen_q) run_q <= 1;
      else if (act)                     run_q <= run_q + 1;
      else                              run_q <= 0;
    end
  end

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_stb_o, wr_stb_o}));

  assert_start_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act) |-> $past(en_i));

  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_cnt_o != $past(pulse_cnt_o)) |-> (pulse_cnt_o == $past(pulse_cnt_o) + CW'(1)));

  assert_start_counted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act) |-> (pulse_cnt_o == $past(pulse_cnt_o) + CW'(1)));

  assert_dvalid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o |-> !act);

  assert_run_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= PULSE_LEN);

  assert_run_exact_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> run_q == PULSE_LEN);
endmodule

bind atd_access_ctrl atd_access_ctrl_chk #(.CW(CW), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .rd_stb_o   (rd_stb_o),
  .wr_stb_o   (wr_stb_o),
  .dvalid_o   (dvalid_o),
  .pulse_cnt_o(pulse_cnt_o)
);

// File: tb/atd_access_ctrl_bench.sv
module atd_access_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, CW = 16, L = 2;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, en = 1'b0;
  logic [DW-1:0] mrd = '0;
  logic          rd_stb, wr_stb, dvalid;
  logic [DW-1:0] rdata;
  logic [CW-1:0] pcnt;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  bit            armed = 1'b0;
  logic [AW:0]   snap = '0;
  logic [DW-1:0] e_rdata = '0;
  bit            e_dv = 1'b0;
  logic [CW-1:0] e_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atd_access_ctrl #(.AW(AW), .DW(DW), .CW(CW), .PULSE_LEN(L)) u_atd_access_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .en_i(en),
    .mem_rdata_i(mrd), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .dvalid_o(dvalid),
    .rdata_o(rdata), .pulse_cnt_o(pcnt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req);
    chk(rdata == e_rdata, req, 32'(rdata), 32'(e_rdata));
    chk(dvalid == e_dv, req, 32'(dvalid), 32'(e_dv));
    chk(pcnt == e_cnt, req, 32'(pcnt), 32'(e_cnt));
  endtask

  // apply request just after a negedge, observe L+1 cycles
  task automatic req(input logic [AW-1:0] a, input logic w, input logic e,
                     input logic [DW-1:0] d, input string tag);
    bit p;
    p = e && (!armed || {w, a} != snap);
    if (p) begin armed = 1'b1; snap = {w, a}; end
    addr = a; we = w; en = e; mrd = d;
    for (int i = 0; i <= L; i++) begin
      @(negedge clk);
      chk(rd_stb == (p && !w && i < L), tag, 32'(rd_stb), 32'(p && !w && i < L));
      chk(wr_stb == (p && w && i < L), tag, 32'(wr_stb), 32'(p && w && i < L));
      if (p && i < L) chk(dvalid == 1'b0, {tag, " R8"}, 32'(dvalid), 0);
    end
    if (p) begin
      e_cnt++;
      if (!w) begin e_rdata = d; e_dv = 1'b1; end
      else e_dv = 1'b0;
    end
    chk_out(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0] lcg;
    logic [AW-1:0] la;
    logic lw;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!rd_stb && !wr_stb, "R1", 32'({rd_stb, wr_stb}), 0);
    chk_out("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!rd_stb && !wr_stb, "R1", 32'({rd_stb, wr_stb}), 0);
    chk_out("R1");

    // R5 first request equals reset snapshot
    req('0, 1'b0, 1'b1, 16'hA5A5, "R5");
    // R4 repeat, new array data must not appear
    req('0, 1'b0, 1'b1, 16'h1111, "R4");

    // R2 every single monitored address bit
    a = '0;
    for (int b = 0; b < AW; b++) begin
      a = a ^ (AW'(1) << b);
      req(a, 1'b0, 1'b1, DW'(16'h0100 + b), "R2");
    end
    // R7 direction bit alone, write then repeat write, back to read
    req(a, 1'b1, 1'b1, 16'hBEEF, "R7");
    req(a, 1'b1, 1'b1, 16'hBEEF, "R4");
    req(a, 1'b0, 1'b1, 16'h7777, "R7");

    // R3 changes while disabled, R10 serviced on enable
    req(16'h1234, 1'b0, 1'b0, 16'h2222, "R3");
    req(16'h4321, 1'b1, 1'b0, 16'h3333, "R3");
    req(16'h4321, 1'b1, 1'b1, 16'h3333, "R10");

    // R6 restart mid-pulse
    addr = 16'h00F0; we = 1'b0; en = 1'b1; mrd = 16'h5555;
    @(negedge clk);
    chk(rd_stb, "R6", 32'(rd_stb), 1);
    addr = 16'h00F1; mrd = 16'h6666;
    for (int i = 0; i <= L; i++) begin
      @(negedge clk);
      chk(rd_stb == (i < L), "R6", 32'(rd_stb), 32'(i < L));
    end
    armed = 1'b1; snap = {1'b0, 16'h00F1};
    e_cnt = e_cnt + 2; e_rdata = 16'h6666; e_dv = 1'b1;
    chk_out("R6 R9");

    // mixed sweep with frequent repeats
    lcg = 32'h1357_9BDF; la = '0; lw = 1'b0;
    for (int k = 0; k < 96; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (k % 3 == 0) req(la, lw, 1'b1, lcg[31:16], "R4");
      else begin
        la = lcg[23:8]; lw = lcg[5];
        req(la, lw, lcg[2:0] != 3'd0, lcg[31:16], "R9");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule